// File: doc/BRIEF.md
# Task-File Sector Transfer Controller

This block is the device side of one disk channel that carries two drive slots. A host bus reaches a small set of byte registers. These are a sector count, three address bytes, a drive/head byte, a combined status/command location and a combined alternate-status/device-control location. A 16-bit data port reaches a one-sector buffer inside the block. The read-sector and write-sector commands move whole sectors between that buffer and a simple word-serial storage port, which sits on the far side.

Every sector that completes is followed by a busy phase. The buffer is streamed to or from storage during that phase, and a configurable extra delay follows. When the busy phase ends, the block either opens the buffer for the next sector or returns to idle, and it raises its interrupt line unless the host has masked it. A read command does not open the buffer to the host at once. It first fetches a sector. A write command opens the buffer immediately. Host accesses that break the transfer protocol are dropped, and they set a sticky error flag.

Top module: `tfx_xfer_ctrl`

Register locations (`bus_addr`): 0 data port, 1 sector count, 2/3/4 address bits 7:0, 15:8 and 23:16, 5 drive/head, 6 status on a read and command on a write, 7 alternate status on a read and device control on a write.

## Requirements
- R1: After reset the status reads 0x40, `irq` and `proto_err` are low, and `stor_stb` is low.
- R2: A read of location 6 or 7 returns the status on `bus_rdata` in the cycle after `bus_rd`. The status is 0x40 when idle, 0x08 while the buffer is open to the host, and 0x80 while busy.
- R3: Command 0x30 or 0x31 written in idle opens the buffer for host writes at once. Command 0x20 or 0x21 enters busy first and fetches one sector before the first data request. Any other code written in idle changes nothing and sets no error.
- R4: The sector count comes from location 1, and a value of 0 means 256 sectors.
- R5: Each data-port write stores one 16-bit word. After SEC_BYTES/2 words the sector is emitted on the storage port: `stor_stb` is high with `stor_we`=1, `stor_word` counts from 0, and `stor_wdata` carries the words in the order they were written.
- R6: During a read, each data-port read returns the next word of the fetched sector, in the order of the storage word index.
- R7: Each busy phase lasts exactly SEC_BYTES/2 + READY_DELAY cycles. It then opens the buffer in the same direction if sectors remain, and otherwise returns to idle.
- R8: The end of each busy phase raises `irq` only when bit 1 of the last device-control write (location 7) is 0.
- R9: A status read at location 6 clears `irq`. An alternate-status read at location 7 leaves it unchanged.
- R10: A device-control write with bit 1 set clears a pending `irq`.
- R11: The first sector's storage byte address is L*SEC_BYTES, where L = {drive/head[3:0], loc4, loc3, loc2}. Each later sector adds SEC_BYTES. `stor_drive` is drive/head bit 4, captured when the command is accepted.
- R12: A data write outside the write buffer phase, a data read outside the read buffer phase, or a command written while not idle sets a sticky `proto_err`. The access is otherwise ignored, and the buffer pointer and state are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 3 | Register location |
| bus_wdata | input | 16 | Host write data (bytes use bits 7:0) |
| bus_rdata | output | 16 | Read result, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt request |
| proto_err | output | 1 | Sticky protocol-violation flag |
| stor_stb | output | 1 | Storage word transfer strobe |
| stor_we | output | 1 | 1 = word goes to storage, 0 = word comes from storage |
| stor_drive | output | 1 | Selected drive slot |
| stor_addr | output | ADDR_W | Byte address of the sector being moved |
| stor_word | output | log2(SEC_BYTES/2) | Word index within the sector |
| stor_wdata | output | 16 | Word sent to storage |
| stor_rdata | input | 16 | Word returned by storage in the same cycle |

## Verification
Register reads are due one cycle after the strobe. The bench therefore drives each access at a falling edge and samples `bus_rdata` at the next falling edge, after the capturing rising edge. A busy phase begins on the edge that accepts the last data word or the read command, and it holds for SEC_BYTES/2 + READY_DELAY edges. The bench polls the alternate status once per cycle and requires exactly that many 0x80 replies before the next state shows. `irq` is due on the edge that ends the busy phase and is checked right after the poll that first sees the new state. Words sent to storage are captured at falling edges while `stor_stb` is high, and they are compared once the busy phase is over.

// File: rtl/tfx_pkg.sv
package tfx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOAD    = 3'd1,
        ST_DRAIN   = 3'd2,
        ST_BUSY_LD = 3'd3,
        ST_BUSY_DR = 3'd4
    } tfx_state_e;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_CNT  = 3'd1;
    localparam logic [2:0] A_LBA0 = 3'd2;
    localparam logic [2:0] A_LBA1 = 3'd3;
    localparam logic [2:0] A_LBA2 = 3'd4;
    localparam logic [2:0] A_DH   = 3'd5;
    localparam logic [2:0] A_STAT = 3'd6;
    localparam logic [2:0] A_ALT  = 3'd7;

    localparam logic [7:0] STAT_RDY  = 8'h40;
    localparam logic [7:0] STAT_DRQ  = 8'h08;
    localparam logic [7:0] STAT_BUSY = 8'h80;

endpackage

// File: rtl/tfx_stat_enc.sv
module tfx_stat_enc
    import tfx_pkg::*;
(
    input  tfx_state_e st,
    output logic [7:0] code
);
    always_comb begin
        unique case (st)
            ST_LOAD, ST_DRAIN:       code = STAT_DRQ;
            ST_BUSY_LD, ST_BUSY_DR:  code = STAT_BUSY;
            default:                 code = STAT_RDY;
        endcase
    end
endmodule

// File: rtl/tfx_sector_buf.sv
module tfx_sector_buf #(
    parameter int WORDS = 256,
    parameter int DW    = 16,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[widx] <= wdata;
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/tfx_xfer_ctrl.sv
module tfx_xfer_ctrl
    import tfx_pkg::*;
#(
    parameter int SEC_BYTES   = 512,
    parameter int READY_DELAY = 16,
    parameter int ADDR_W      = 40,
    localparam int SEC_WORDS  = SEC_BYTES / 2,
    localparam int IDX_W      = $clog2(SEC_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq,
    output logic              proto_err,
    output logic              stor_stb,
    output logic              stor_we,
    output logic              stor_drive,
    output logic [ADDR_W-1:0] stor_addr,
    output logic [IDX_W-1:0]  stor_word,
    output logic [15:0]       stor_wdata,
    input  logic [15:0]       stor_rdata
);
    localparam int BUSY_LEN = SEC_WORDS + READY_DELAY;
    localparam int BCNT_W   = $clog2(BUSY_LEN);
    localparam int SHIFT    = $clog2(SEC_BYTES);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(SEC_WORDS - 1);
    localparam logic [BCNT_W-1:0] BUSY_LAST = BCNT_W'(BUSY_LEN - 1);
    localparam logic [BCNT_W-1:0] XFER_END  = BCNT_W'(SEC_WORDS);

    typedef struct packed {
        tfx_state_e        st;
        logic [8:0]        rem;
        logic [IDX_W-1:0]  ptr;
        logic [BCNT_W-1:0] bcnt;
        logic              xfer;
        logic              drv;
        logic [ADDR_W-1:0] baddr;
        logic [7:0]        cnt;
        logic [7:0]        lba0;
        logic [7:0]        lba1;
        logic [7:0]        lba2;
        logic [7:0]        dh;
        logic              nien;
        logic              irq;
        logic              perr;
        logic [15:0]       rdata;
    } ctrl_s;

    ctrl_s q, d;

    logic             busy_q;
    logic [7:0]       stat;
    logic             buf_we;
    logic [IDX_W-1:0] buf_widx;
    logic [15:0]      buf_wdata;
    logic [IDX_W-1:0] buf_ridx;
    logic [15:0]      buf_rdata;
    logic [8:0]       sec_n;
    logic [27:0]      lba;

    assign busy_q   = (q.st == ST_BUSY_LD) || (q.st == ST_BUSY_DR);
    assign stor_stb = busy_q && q.xfer && (q.bcnt < XFER_END);
    assign buf_ridx = busy_q ? q.bcnt[IDX_W-1:0] : q.ptr;

    tfx_stat_enc stat_i (.st(q.st), .code(stat));

    tfx_sector_buf #(.WORDS(SEC_WORDS), .DW(16)) buf_i (
        .clk(clk), .we(buf_we), .widx(buf_widx), .wdata(buf_wdata),
        .ridx(buf_ridx), .rdata(buf_rdata)
    );

    always_comb begin
        d         = q;
        sec_n     = (q.cnt == 8'd0) ? 9'd256 : {1'b0, q.cnt};
        lba       = {q.dh[3:0], q.lba2, q.lba1, q.lba0};
        buf_we    = 1'b0;
        buf_widx  = q.ptr;
        buf_wdata = bus_wdata;

        // storage side of the busy phase
        if (stor_stb && q.st == ST_BUSY_DR) begin
            buf_we    = 1'b1;
            buf_widx  = q.bcnt[IDX_W-1:0];
            buf_wdata = stor_rdata;
        end
        if (busy_q) begin
            if (q.bcnt == BUSY_LAST) begin
                d.bcnt = '0;
                d.xfer = 1'b0;
                if (q.xfer) d.baddr = q.baddr + ADDR_W'(SEC_BYTES);
                if (q.rem != 9'd0)
                    d.st = (q.st == ST_BUSY_LD) ? ST_LOAD : ST_DRAIN;
                else
                    d.st = ST_IDLE;
                if (!q.nien) d.irq = 1'b1;
            end else begin
                d.bcnt = q.bcnt + 1'b1;
            end
        end

        // host writes
        if (bus_wr) begin
            unique case (bus_addr)
                A_DATA: begin
                    if (q.st == ST_LOAD) begin
                        buf_we = 1'b1;
                        d.ptr  = q.ptr + 1'b1;
                        if (q.ptr == LAST_IDX) begin
                            d.ptr  = '0;
                            d.rem  = q.rem - 9'd1;
                            d.st   = ST_BUSY_LD;
                            d.xfer = 1'b1;
                            d.bcnt = '0;
                        end
                    end else begin
                        d.perr = 1'b1;
                    end
                end
                A_CNT:  d.cnt  = bus_wdata[7:0];
                A_LBA0: d.lba0 = bus_wdata[7:0];
                A_LBA1: d.lba1 = bus_wdata[7:0];
                A_LBA2: d.lba2 = bus_wdata[7:0];
                A_DH:   d.dh   = bus_wdata[7:0];
                A_STAT: begin
                    if (q.st != ST_IDLE) begin
                        d.perr = 1'b1;
                    end else if (bus_wdata[7:1] == 7'h10 || bus_wdata[7:1] == 7'h18) begin
                        d.rem   = sec_n;
                        d.ptr   = '0;
                        d.bcnt  = '0;
                        d.drv   = q.dh[4];
                        d.baddr = ADDR_W'(lba) << SHIFT;
                        if (bus_wdata[7:1] == 7'h10) begin
                            d.st   = ST_BUSY_DR;
                            d.xfer = 1'b1;
                        end else begin
                            d.st   = ST_LOAD;
                        end
                    end
                end
                default: begin
                    d.nien = bus_wdata[1];
                    if (bus_wdata[1]) d.irq = 1'b0;
                end
            endcase
        end

        // host reads
        if (bus_rd) begin
            unique case (bus_addr)
                A_DATA: begin
                    if (q.st == ST_DRAIN) begin
                        d.rdata = buf_rdata;
                        d.ptr   = q.ptr + 1'b1;
                        if (q.ptr == LAST_IDX) begin
                            d.ptr  = '0;
                            d.rem  = q.rem - 9'd1;
                            d.st   = ST_BUSY_DR;
                            d.xfer = (q.rem != 9'd1);
                            d.bcnt = '0;
                        end
                    end else begin
                        d.rdata = '0;
                        d.perr  = 1'b1;
                    end
                end
                A_CNT:  d.rdata = {8'h00, q.cnt};
                A_LBA0: d.rdata = {8'h00, q.lba0};
                A_LBA1: d.rdata = {8'h00, q.lba1};
                A_LBA2: d.rdata = {8'h00, q.lba2};
                A_DH:   d.rdata = {8'h00, q.dh};
                A_STAT: begin
                    d.rdata = {8'h00, stat};
                    d.irq   = 1'b0;
                end
                default: d.rdata = {8'h00, stat};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata  = q.rdata;
    assign irq        = q.irq;
    assign proto_err  = q.perr;
    assign stor_we    = (q.st == ST_BUSY_LD);
    assign stor_drive = q.drv;
    assign stor_addr  = q.baddr;
    assign stor_word  = q.bcnt[IDX_W-1:0];
    assign stor_wdata = buf_rdata;

    // R9
    stat_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |=> !irq);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(!q.nien));

    // R12
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R12
    cmd_in_xfer_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STAT && (q.st == ST_LOAD || q.st == ST_DRAIN))
        |=> (q.st == $past(q.st) && q.ptr == $past(q.ptr)));

    // R2
    stb_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stor_stb |-> (stat == STAT_BUSY));
endmodule

// File: tb/tfx_xfer_ctrl_tb.sv
module tfx_xfer_ctrl_tb_top;
    localparam int WORDS = 8;
    localparam int BUSY  = WORDS + 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, proto_err, stor_stb, stor_we, stor_drive;
    logic [39:0] stor_addr;
    logic [2:0]  stor_word;
    logic [15:0] stor_wdata, stor_rdata;

    int total = 0;
    int bad = 0;

    logic [15:0] cap [WORDS];
    logic [39:0] cap_addr;
    logic        cap_drv;

    always #4 clk = ~clk;

    tfx_xfer_ctrl #(.SEC_BYTES(16), .READY_DELAY(4), .ADDR_W(40)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .proto_err(proto_err), .stor_stb(stor_stb), .stor_we(stor_we),
        .stor_drive(stor_drive), .stor_addr(stor_addr), .stor_word(stor_word),
        .stor_wdata(stor_wdata), .stor_rdata(stor_rdata)
    );

    function automatic logic [15:0] exp_word(input logic [39:0] a, input int i);
        return a[15:0] ^ {8'(i), 8'h00} ^ 16'h3C5A;
    endfunction

    function automatic logic [15:0] wdat(input int s, input int i);
        return 16'(s * 131 + i * 7) ^ 16'hC3A0;
    endfunction

    assign stor_rdata = exp_word(stor_addr, int'(stor_word));

    always @(negedge clk) begin
        if (stor_stb && stor_we) begin
            cap[int'(stor_word)] = stor_wdata;
            cap_addr = stor_addr;
            cap_drv  = stor_drive;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] dt);
        bus_addr = a; bus_wdata = dt; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic setup(input logic [7:0] cnt, input bit drv, input logic [27:0] lba);
        wr(3'd1, {8'h00, cnt});
        wr(3'd2, {8'h00, lba[7:0]});
        wr(3'd3, {8'h00, lba[15:8]});
        wr(3'd4, {8'h00, lba[23:16]});
        wr(3'd5, {8'h00, 3'b010, drv, lba[27:24]});
    endtask

    task automatic poll(output int n, output logic [15:0] v);
        n = 0;
        rd(3'd7, v);
        while (v == 16'h0080 && n < 1000) begin
            n++;
            rd(3'd7, v);
        end
    endtask

    task automatic after_busy(input bit exp_irq);
        logic [15:0] v;
        chk("R8", "irq at end of busy", irq, exp_irq);
        if (exp_irq) begin
            rd(3'd7, v);
            chk("R9", "alt status keeps irq", irq, 1);
        end
        rd(3'd6, v);
        chk("R9", "status read clears irq", irq, 0);
    endtask

    task automatic run_write(input logic [7:0] code, input logic [7:0] cnt,
                             input bit drv, input logic [27:0] lba, input bit exp_irq);
        logic [15:0] v;
        int n, bn, mism;
        setup(cnt, drv, lba);
        wr(3'd6, {8'h00, code});
        rd(3'd7, v);
        chk("R3", "write opens buffer at once", v, 16'h0008);
        n = (cnt == 8'd0) ? 256 : int'(cnt);
        for (int s = 0; s < n; s++) begin
            for (int i = 0; i < WORDS; i++) wr(3'd0, wdat(s, i));
            poll(bn, v);
            chk("R7", "busy cycles after loaded sector", bn, BUSY);
            mism = 0;
            for (int i = 0; i < WORDS; i++) if (cap[i] !== wdat(s, i)) mism++;
            chk("R5", "sector words on storage port", mism, 0);
            chk("R11", "storage byte address", cap_addr, (40'(lba) + 40'(s)) << 4);
            chk("R11", "drive select", cap_drv, drv);
            chk("R4", "state after sector", v, (s == n - 1) ? 16'h0040 : 16'h0008);
            after_busy(exp_irq);
        end
    endtask

    task automatic run_read(input logic [7:0] code, input logic [7:0] cnt,
                            input bit drv, input logic [27:0] lba);
        logic [15:0] v;
        int n, bn, mism;
        setup(cnt, drv, lba);
        wr(3'd6, {8'h00, code});
        poll(bn, v);
        chk("R3", "read fetches before data request", bn, BUSY);
        chk("R2", "data request after fetch", v, 16'h0008);
        after_busy(1'b1);
        n = (cnt == 8'd0) ? 256 : int'(cnt);
        for (int s = 0; s < n; s++) begin
            mism = 0;
            for (int i = 0; i < WORDS; i++) begin
                rd(3'd0, v);
                if (v !== exp_word((40'(lba) + 40'(s)) << 4, i)) mism++;
            end
            chk("R6", "read words match storage", mism, 0);
            poll(bn, v);
            chk("R7", "busy cycles after drained sector", bn, BUSY);
            chk("R7", "state after sector", v, (s == n - 1) ? 16'h0040 : 16'h0008);
            after_busy(1'b1);
        end
    endtask

    localparam logic [47:0] VEC [5] = '{
        48'h30_01_0_0000010,
        48'h31_03_1_1000200,
        48'h20_02_0_0000005,
        48'h21_01_1_0001234,
        48'h20_03_0_00000FF
    };

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [47:0] e;
        int bn;
        do_reset();
        // R1 reset state
        chk("R1", "irq after reset", irq, 0);
        chk("R1", "proto_err after reset", proto_err, 0);
        chk("R1", "stor_stb after reset", stor_stb, 0);
        rd(3'd6, v);
        chk("R1", "status after reset", v, 16'h0040);

        // table walk
        for (int k = 0; k < 5; k++) begin
            e = VEC[k];
            if (e[47:44] == 4'h3) run_write(e[47:40], e[39:32], e[28], e[27:0], 1'b1);
            else                  run_read(e[47:40], e[39:32], e[28], e[27:0]);
        end

        // R3 unknown command ignored
        wr(3'd6, 16'h0050);
        rd(3'd7, v);
        chk("R3", "unknown code leaves idle", v, 16'h0040);
        chk("R3", "unknown code no error", proto_err, 0);

        // R8 masked interrupt
        wr(3'd7, 16'h0002);
        run_write(8'h30, 8'd1, 1'b0, 28'h0000040, 1'b0);
        wr(3'd7, 16'h0000);

        // R10 device control clears pending irq
        setup(8'd1, 1'b0, 28'h0000020);
        wr(3'd6, 16'h0020);
        poll(bn, v);
        chk("R8", "irq after fetch", irq, 1);
        wr(3'd7, 16'h0002);
        chk("R10", "control bit clears irq", irq, 0);
        wr(3'd7, 16'h0000);
        chk("R10", "unmask does not re-raise", irq, 0);
        for (int i = 0; i < WORDS; i++) rd(3'd0, v);
        poll(bn, v);
        chk("R7", "idle after single read", v, 16'h0040);
        after_busy(1'b1);

        // R4 count zero means 256
        run_write(8'h30, 8'd0, 1'b1, 28'h0000000, 1'b1);

        // R12 protocol errors
        do_reset();
        rd(3'd0, v);
        chk("R12", "data read in idle flags", proto_err, 1);
        rd(3'd7, v);
        chk("R12", "data read in idle ignored", v, 16'h0040);
        do_reset();
        wr(3'd0, 16'h1234);
        chk("R12", "data write in idle flags", proto_err, 1);
        do_reset();
        setup(8'd1, 1'b0, 28'h0000003);
        wr(3'd6, 16'h0030);
        wr(3'd6, 16'h0020);
        chk("R12", "command while loading flags", proto_err, 1);
        rd(3'd7, v);
        chk("R12", "command while loading ignored", v, 16'h0008);
        for (int i = 0; i < 4; i++) wr(3'd0, wdat(0, i));
        rd(3'd0, v);
        for (int i = 4; i < WORDS; i++) wr(3'd0, wdat(0, i));
        poll(bn, v);
        chk("R12", "pointer untouched by bad read", bn, BUSY);
        bn = 0;
        for (int i = 0; i < WORDS; i++) if (cap[i] !== wdat(0, i)) bn++;
        chk("R12", "sector intact after bad accesses", bn, 0);
        chk("R12", "error stays set", proto_err, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule